// File: doc/BRIEF.md
# Hard-Decision Chip Sequence Correlator

This block watches a serial stream of hard-decided spreading chips and measures how closely the most recent chips match a reference spreading code. Every accepted chip moves a window of the newest chips along by one place. Each window position is compared with its reference chip through one equality (XNOR) gate. The number of agreeing positions, taken over the selected code length L, is registered as a match count.

When the count reaches a programmable threshold, a one-cycle detect pulse is raised. The pulse can only appear once at least L chips have been accepted since reset. The reference is either one of seven built-in Barker codes (lengths 2 to 13) or a pattern of up to 13 chips that the user loads.

A chip is encoded as logic 0 for −1 and logic 1 for +1. The chip input is a valid/ready stream. The block never applies back-pressure: `chip_ready` stays high, and a chip transfers on every clock edge where `chip_valid` is high. The code select, load and threshold pins are plain control pins, sampled at each edge.

Top module: `chip_correlator`

## Requirements
- R1: After reset, `match_count` is 0, `detect` is 0, and the window holds all zeros (all −1 chips).
- R2: The window and `match_count` change only at an edge where `chip_valid` is high. In every cycle that follows an edge without a valid chip, `match_count` is unchanged and `detect` is 0.
- R3: After an edge that accepts a chip, `match_count` gives the number of positions j in 0..L-1 where the j-th oldest of the last L accepted chips equals chip j of the reference. Chip 0 is the first chip transmitted, and a −1 chip is 0.
- R4: `code_sel` picks the reference: 0 = loaded pattern, 1 = length 2 (−+), 2 = length 3 (−−+), 3 = length 4 (−−+−), 4 = length 5 (−−−+−), 5 = length 7 (−−−++−+), 6 = length 11 (−−−+++−++−+), 7 = length 13 (−−−−−++−−+−+−).
- R5: With a Barker code selected, its exact arrival yields `match_count` = L. Every partial or shifted alignment, whether the code is preceded or followed by −1 chips, yields less than L.
- R6: A high `pn_load` at an edge captures `pn_pattern` and `pn_len` for code 0. The pattern is right-justified, and chip j sits at bit L-1-j. A length of 0 is taken as 1, and a length above 13 is taken as 13.
- R7: `detect` is 1 in the cycle after an accepting edge exactly when the new count is at least `threshold` and the window is filled.
- R8: The window is filled once at least L chips have been accepted since reset. Before that, `detect` stays 0 even with `threshold` = 0.
- R9: `chip_ready` is 1 in every cycle, including reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_valid | input | 1 | A chip is offered this cycle |
| chip_ready | output | 1 | Always 1; the block accepts every chip |
| chip_data | input | 1 | Chip value, 1 = +1, 0 = −1 |
| code_sel | input | 3 | Reference selection, see R4 |
| pn_load | input | 1 | Captures the loadable pattern and its length |
| pn_pattern | input | 13 | Loadable pattern, right-justified, first chip at the highest used bit |
| pn_len | input | 4 | Loadable pattern length, clamped to 1..13 |
| threshold | input | 4 | Minimum agreement count for a detect |
| match_count | output | 4 | Registered agreement count |
| detect | output | 1 | One-cycle pulse when the count meets the threshold |

## Verification
The assertions take for granted that `chip_valid` and `chip_data` carry known values after reset. They also assume that `code_sel`, `threshold` and the load pins are only looked at on clock edges. The count bound is therefore checked against the length captured alongside the count, not against the live selection. Reference changes in the middle of a stream are legal. The stimulus changes every input only at the falling clock edge and reads the outputs at the next falling edge. It switches codes only between runs, so each run's expected count comes from one known reference.

// File: rtl/chipcorr_pkg.sv
package chipcorr_pkg;

  localparam int BARKER_MAX = 13;

  typedef enum logic [2:0] {
    SEL_LOADED = 3'd0,
    SEL_B2     = 3'd1,
    SEL_B3     = 3'd2,
    SEL_B4     = 3'd3,
    SEL_B5     = 3'd4,
    SEL_B7     = 3'd5,
    SEL_B11    = 3'd6,
    SEL_B13    = 3'd7
  } code_sel_e;

  // Right-justified, first transmitted chip at the highest used bit.
  // A -1 chip is stored as 0.
  function automatic logic [BARKER_MAX-1:0] barker_bits(input code_sel_e sel);
    case (sel)
      SEL_B2:  barker_bits = BARKER_MAX'(2'b01);
      SEL_B3:  barker_bits = BARKER_MAX'(3'b001);
      SEL_B4:  barker_bits = BARKER_MAX'(4'b0010);
      SEL_B5:  barker_bits = BARKER_MAX'(5'b00010);
      SEL_B7:  barker_bits = BARKER_MAX'(7'b0001101);
      SEL_B11: barker_bits = BARKER_MAX'(11'b00011101101);
      SEL_B13: barker_bits = 13'b0000011001010;
      default: barker_bits = '0;
    endcase
  endfunction

  function automatic int barker_len(input code_sel_e sel);
    case (sel)
      SEL_B2:  barker_len = 2;
      SEL_B3:  barker_len = 3;
      SEL_B4:  barker_len = 4;
      SEL_B5:  barker_len = 5;
      SEL_B7:  barker_len = 7;
      SEL_B11: barker_len = 11;
      SEL_B13: barker_len = 13;
      default: barker_len = 1;
    endcase
  endfunction

endpackage

// File: rtl/ref_select.sv
module ref_select
  import chipcorr_pkg::*;
#(
  parameter int MAX_LEN = BARKER_MAX,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         code_sel,
  input  logic               pn_load,
  input  logic [MAX_LEN-1:0] pn_pattern,
  input  logic [CNT_W-1:0]   pn_len,
  output logic [MAX_LEN-1:0] ref_bits,
  output logic [CNT_W-1:0]   ref_len
);

  logic [MAX_LEN-1:0] pat_q;
  logic [CNT_W-1:0]   len_q;
  logic [CNT_W-1:0]   len_clamped;
  code_sel_e          sel;

  assign sel = code_sel_e'(code_sel);

  always_comb begin
    if (pn_len == '0)
      len_clamped = CNT_W'(1);
    else if (pn_len > CNT_W'(MAX_LEN))
      len_clamped = CNT_W'(MAX_LEN);
    else
      len_clamped = pn_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      len_q <= CNT_W'(MAX_LEN);
    end else if (pn_load) begin
      pat_q <= pn_pattern;
      len_q <= len_clamped;
    end
  end

  always_comb begin
    if (sel == SEL_LOADED) begin
      ref_bits = pat_q;
      ref_len  = len_q;
    end else begin
      ref_bits = MAX_LEN'(barker_bits(sel));
      ref_len  = CNT_W'(barker_len(sel));
    end
  end

  // R6: the captured length is always a usable length
  a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= CNT_W'(1)) && (len_q <= CNT_W'(MAX_LEN)));

  // R6: a load takes the offered pattern
  a_r6_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    pn_load |=> (pat_q == $past(pn_pattern)));

endmodule

// File: rtl/chip_window.sv
module chip_window #(
  parameter int MAX_LEN = 13,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chip_valid,
  input  logic               chip_data,
  input  logic [CNT_W-1:0]   ref_len,
  output logic [MAX_LEN-1:0] win_q,
  output logic [MAX_LEN-1:0] win_d,
  output logic               filled_d
);

  logic [CNT_W-1:0] fill_q;
  logic [CNT_W-1:0] fill_d;

  // Newest chip enters at bit 0; older chips move toward the top.
  always_comb begin
    if (chip_valid) begin
      win_d  = {win_q[MAX_LEN-2:0], chip_data};
      fill_d = (fill_q == CNT_W'(MAX_LEN)) ? fill_q : fill_q + CNT_W'(1);
    end else begin
      win_d  = win_q;
      fill_d = fill_q;
    end
  end

  assign filled_d = (fill_d >= ref_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

  // R2: no chip, no movement
  a_r2_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |=> $stable(win_q));

  // R2: an accepted chip lands at the newest position
  a_r2_window_entry: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid |=> (win_q[0] == $past(chip_data)));

  // R8: fill count saturates at the window size
  a_r8_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(MAX_LEN));

endmodule

// File: rtl/agree_counter.sv
module agree_counter #(
  parameter int MAX_LEN = 13,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chip_valid,
  input  logic [MAX_LEN-1:0] win_d,
  input  logic [MAX_LEN-1:0] ref_bits,
  input  logic [CNT_W-1:0]   ref_len,
  input  logic               filled_d,
  input  logic [CNT_W-1:0]   threshold,
  output logic [CNT_W-1:0]   match_count,
  output logic               detect
);

  logic [MAX_LEN-1:0] agree;
  logic [CNT_W-1:0]   sum;
  logic [CNT_W-1:0]   len_q;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_xnor
    assign agree[g] = ~(win_d[g] ^ ref_bits[g]) & (CNT_W'(g) < ref_len);
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < MAX_LEN; i++)
      sum = sum + CNT_W'(agree[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_count <= '0;
      detect      <= 1'b0;
      len_q       <= CNT_W'(1);
    end else if (chip_valid) begin
      match_count <= sum;
      detect      <= filled_d && (sum >= threshold);
      len_q       <= ref_len;
    end else begin
      detect      <= 1'b0;
    end
  end

  // R2: count holds and detect is quiet after an idle edge
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |=> ($stable(match_count) && !detect));

  // R7: a detect is always backed by a count at the threshold
  a_r7_detect_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect) |-> (match_count >= $past(threshold)));

  // R7: detect only follows an accepting edge
  a_r7_detect_after_chip: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> $past(chip_valid));

  // R3: agreement never exceeds the code length in force
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    match_count <= len_q);

endmodule

// File: rtl/chip_correlator.sv
module chip_correlator
  import chipcorr_pkg::*;
#(
  parameter int MAX_LEN = BARKER_MAX,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chip_valid,
  output logic               chip_ready,
  input  logic               chip_data,
  input  logic [2:0]         code_sel,
  input  logic               pn_load,
  input  logic [MAX_LEN-1:0] pn_pattern,
  input  logic [CNT_W-1:0]   pn_len,
  input  logic [CNT_W-1:0]   threshold,
  output logic [CNT_W-1:0]   match_count,
  output logic               detect
);

  logic [MAX_LEN-1:0] ref_bits;
  logic [CNT_W-1:0]   ref_len;
  logic [MAX_LEN-1:0] win_q;
  logic [MAX_LEN-1:0] win_d;
  logic               filled_d;

  assign chip_ready = 1'b1;

  ref_select #(.MAX_LEN(MAX_LEN)) u_ref (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_sel   (code_sel),
    .pn_load    (pn_load),
    .pn_pattern (pn_pattern),
    .pn_len     (pn_len),
    .ref_bits   (ref_bits),
    .ref_len    (ref_len)
  );

  chip_window #(.MAX_LEN(MAX_LEN)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_valid (chip_valid),
    .chip_data  (chip_data),
    .ref_len    (ref_len),
    .win_q      (win_q),
    .win_d      (win_d),
    .filled_d   (filled_d)
  );

  agree_counter #(.MAX_LEN(MAX_LEN)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_valid  (chip_valid),
    .win_d       (win_d),
    .ref_bits    (ref_bits),
    .ref_len     (ref_len),
    .filled_d    (filled_d),
    .threshold   (threshold),
    .match_count (match_count),
    .detect      (detect)
  );

  // R1: the window starts from all -1 chips
  a_r1_window_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (win_q == '0));

endmodule

// File: tb/chip_correlator_tb_top.sv
`timescale 1ns/1ps
module chip_correlator_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_valid = 1'b0;
  logic        chip_ready;
  logic        chip_data = 1'b0;
  logic [2:0]  code_sel = 3'd5;
  logic        pn_load = 1'b0;
  logic [12:0] pn_pattern = '0;
  logic [3:0]  pn_len = 4'd0;
  logic [3:0]  threshold = 4'd0;
  logic [3:0]  match_count;
  logic        detect;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [12:0] mwin = '0;
  int          mfill = 0;
  logic [12:0] ebits;
  int          elen;
  int          last_cnt = 0;
  logic [7:0]  lf = 8'h5b;

  always #4 clk = ~clk;

  chip_correlator dut_i (
    .clk(clk), .rst_n(rst_n), .chip_valid(chip_valid), .chip_ready(chip_ready),
    .chip_data(chip_data), .code_sel(code_sel), .pn_load(pn_load),
    .pn_pattern(pn_pattern), .pn_len(pn_len), .threshold(threshold),
    .match_count(match_count), .detect(detect)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] bits_of(input int sel);
    case (sel)
      1: return 13'b0000000000001;
      2: return 13'b0000000000001;
      3: return 13'b0000000000010;
      4: return 13'b0000000000010;
      5: return 13'b0000000001101;
      6: return 13'b0000011101101;
      7: return 13'b0000011001010;
      default: return '0;
    endcase
  endfunction

  function automatic int len_of(input int sel);
    case (sel)
      1: return 2;  2: return 3;  3: return 4;  4: return 5;
      5: return 7;  6: return 11; 7: return 13;
      default: return 1;
    endcase
  endfunction

  function automatic int model_count();
    int n = 0;
    for (int i = 0; i < elen; i++)
      if (mwin[i] == ebits[i]) n++;
    return n;
  endfunction

  // Entered at a falling edge; returns at the next falling edge after checking.
  task automatic push(input logic c, input string req);
    int ec;
    bit ed;
    chip_valid = 1'b1;
    chip_data  = c;
    @(posedge clk);
    mwin = {mwin[11:0], c};
    if (mfill < 13) mfill++;
    ec = model_count();
    ed = (mfill >= elen) && (ec >= int'(threshold));
    @(negedge clk);
    chip_valid = 1'b0;
    chk(int'(match_count) == ec, {req, " count"}, match_count, ec);
    chk(detect == ed, {req, " detect"}, detect, ed);
    last_cnt = ec;
  endtask

  task automatic idle_cycle();
    chip_valid = 1'b0;
    chip_data  = ~chip_data;
    @(posedge clk);
    @(negedge clk);
    chk(int'(match_count) == last_cnt, "R2 idle hold", match_count, last_cnt);
    chk(detect == 1'b0, "R2 idle detect", detect, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(match_count == 4'd0, "R1 reset count", match_count, 0);
    chk(detect == 1'b0, "R1 reset detect", detect, 0);
    chk(chip_ready == 1'b1, "R9 ready in reset", chip_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    mwin = '0;
    mfill = 0;
  endtask

  task automatic t_fill();
    code_sel = 3'd5;
    ebits = bits_of(5);
    elen = 7;
    threshold = 4'd0;
    for (int k = 0; k < 6; k++) begin
      push(1'b1, "R8 unfilled");
      chk(detect == 1'b0, "R8 blocked before fill", detect, 0);
    end
    push(1'b0, "R8 just filled");
    chk(detect == 1'b1, "R8 first detect", detect, 1);
    chk(chip_ready == 1'b1, "R9 ready running", chip_ready, 1);
  endtask

  task automatic t_barker(input int sel);
    logic [12:0] b;
    int l;
    b = bits_of(sel);
    l = len_of(sel);
    code_sel = 3'(sel);
    ebits = b;
    elen = l;
    threshold = 4'(l);
    for (int k = 0; k < l; k++) push(1'b0, "R4 pad");
    for (int k = l - 1; k >= 0; k--) begin
      push(b[k], "R3 code");
      if (k == 0) begin
        chk(int'(match_count) == l, "R5 peak", match_count, l);
        chk(detect == 1'b1, "R5 peak detect", detect, 1);
      end else begin
        chk(int'(match_count) < l, "R5 lead sidelobe", match_count, l - 1);
      end
    end
    for (int k = 0; k < l; k++) begin
      push(1'b0, "R4 tail");
      chk(int'(match_count) < l, "R5 tail sidelobe", match_count, l - 1);
    end
  endtask

  task automatic t_gaps();
    code_sel = 3'd7;
    ebits = bits_of(7);
    elen = 13;
    threshold = 4'd13;
    for (int k = 12; k >= 0; k--) begin
      push(ebits[k], "R2 gapped code");
      if (k % 3 == 0) begin
        idle_cycle();
        idle_cycle();
      end
    end
    chk(int'(match_count) == 13, "R2 gapped peak", match_count, 13);
    idle_cycle();
  endtask

  task automatic load(input logic [12:0] pat, input logic [3:0] len);
    pn_pattern = pat;
    pn_len = len;
    pn_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pn_load = 1'b0;
    pn_pattern = '0;
    pn_len = 4'd0;
  endtask

  task automatic t_loaded();
    load(13'b0000000101100, 4'd6);
    code_sel = 3'd0;
    ebits = 13'b0000000101100;
    elen = 6;
    threshold = 4'd6;
    for (int k = 0; k < 6; k++) push(1'b1, "R6 pre");
    for (int k = 5; k >= 0; k--) push(ebits[k], "R6 pattern");
    chk(int'(match_count) == 6, "R6 loaded peak", match_count, 6);
    chk(detect == 1'b1, "R6 loaded detect", detect, 1);
  endtask

  task automatic t_clamp();
    load(13'b0000000000001, 4'd0);
    ebits = 13'b0000000000001;
    elen = 1;
    threshold = 4'd1;
    push(1'b1, "R6 zero len");
    chk(match_count == 4'd1, "R6 len0 as 1 match", match_count, 1);
    push(1'b0, "R6 zero len");
    chk(match_count == 4'd0, "R6 len0 as 1 miss", match_count, 0);
    load(13'h1FFF, 4'd15);
    ebits = 13'h1FFF;
    elen = 13;
    threshold = 4'd13;
    for (int k = 0; k < 13; k++) push(1'b1, "R6 long len");
    chk(match_count == 4'd13, "R6 len15 as 13", match_count, 13);
  endtask

  task automatic t_stream();
    code_sel = 3'd6;
    ebits = bits_of(6);
    elen = 11;
    threshold = 4'd7;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      push(lf[0], "R7 mixed stream");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    for (int s = 1; s <= 7; s++) t_barker(s);
    t_gaps();
    t_loaded();
    t_clamp();
    t_stream();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule